// File: doc/BRIEF.md
# Escaped Byte Stream Serializer

This block is the transmit half of a framed serial link. It pulls bytes from an upstream queue through a valid/ready handshake and shifts them out one bit per clock, most significant bit first. The serial bit is meant to be sampled on the rising clock edge. A strobe marks the first bit of every byte-wide slot.

Slots are grouped into frames of seven. The first slot of every frame always carries the sync character 0xB2. The six slots that follow carry data, an idle filler (0x81) when nothing is waiting, or an escape prefix (0xE7). A data byte that equals the idle or escape code is sent in two slots: the escape prefix goes in the first and the byte itself in the next non-sync slot. If a sync slot comes between the two, the byte waits through it. A data byte equal to the sync code needs no escape. A receiver tells it apart from a real sync by its slot position.

An enable input gates the intake of new bytes only. The slot timing continues while the path is disabled, so sync and idle keep going out. A byte that was already taken into the block is still sent.

Top module: `esc_ser_tx`

## Requirements
- R1: In the first cycle after reset is released, `slot_start` is 1, the slot being sent is a sync slot (0xB2, so `ser_bit` is 1), and `fifo_ready` is 0.
- R2: Each slot lasts 8 clocks. `slot_start` is 1 exactly in the first clock of each slot, and the slot's byte goes out on `ser_bit` most significant bit first.
- R3: Slot 0 of each 7-slot frame carries 0xB2. The first slot after reset is slot 0. No byte is popped into a sync slot.
- R4: A non-sync slot with no byte available and no byte held inside the block carries the idle code 0x81.
- R5: Bytes are accepted (`fifo_ready` and `fifo_valid` both 1 at a clock edge) only in the last clock of a slot, and they are sent in the order accepted.
- R6: An accepted byte equal to 0x81 or 0xE7 is sent in the next slot as the escape code 0xE7. The byte itself follows in the next non-sync slot.
- R7: An accepted byte equal to 0xB2 is sent in the next slot without an escape prefix.
- R8: When an escape prefix fills slot 6, slot 0 carries the sync and the escaped byte goes out in slot 1.
- R9: While `tx_en` is 0, `fifo_ready` stays 0 and only sync and idle are sent. A byte already held behind its escape prefix is still sent.
- R10: No byte is accepted while a byte is held behind its escape prefix. A byte waiting upstream is kept and sent after the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; serial bits change after its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Allows new bytes to be taken from the queue |
| fifo_valid | input | 1 | Queue has a byte on `fifo_data` |
| fifo_data | input | 8 | Byte at the head of the queue |
| fifo_ready | output | 1 | Block takes the head byte at this clock edge if `fifo_valid` is 1 |
| ser_bit | output | 1 | Serial data bit |
| slot_start | output | 1 | High in the first clock of each byte slot |

## Verification
The bench rebuilds the byte stream from the serial pins, checks every seventh slot for the sync code, and strips escapes and idle to recover the data. A design that dropped escapes, or escaped 0xB2, would show a mismatch in the recovered byte or in its escape flag. An escaped byte is forced to land its prefix in slot 6. A design that broke the split there would put the data byte into the sync slot, or lose it. A second byte queued behind the escaped one catches a block that pops while holding, because that byte would then be dropped or reordered. With the path disabled, the bench checks that nothing is popped and that a byte held when the enable falls is still sent.

// File: rtl/esc_ser_pkg.sv
package esc_ser_pkg;
    localparam int          CHAR_W   = 8;
    localparam logic [7:0]  SYNC_DEF = 8'hB2;
    localparam logic [7:0]  IDLE_DEF = 8'h81;
    localparam logic [7:0]  ESC_DEF  = 8'hE7;
endpackage

// File: rtl/esc_ser_timer.sv
module esc_ser_timer #(
    parameter int W           = 8,
    parameter int FRAME_SLOTS = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic                           first_bit,
    output logic                           last_bit,
    output logic                           next_is_sync,
    output logic [$clog2(FRAME_SLOTS)-1:0] slot_idx
);
    localparam int BW = $clog2(W);
    localparam int SW = $clog2(FRAME_SLOTS);

    typedef struct packed {
        logic [BW-1:0] bit_i;
        logic [SW-1:0] slot_i;
    } tmr_t;

    tmr_t r_d, r_q;
    logic wrap;

    always_comb begin
        r_d      = r_q;
        last_bit = (r_q.bit_i == BW'(W - 1));
        wrap     = (r_q.slot_i == SW'(FRAME_SLOTS - 1));
        if (last_bit) begin
            r_d.bit_i  = '0;
            r_d.slot_i = wrap ? '0 : r_q.slot_i + 1'b1;
        end else begin
            r_d.bit_i  = r_q.bit_i + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign first_bit    = (r_q.bit_i == '0);
    assign next_is_sync = wrap;
    assign slot_idx     = r_q.slot_i;

    // R3: slot index stays inside the frame
    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.slot_i < SW'(FRAME_SLOTS));

    // R3: leaving the last slot of a frame lands on slot 0, bit 0
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && next_is_sync) |=> (slot_idx == '0 && first_bit));
endmodule

// File: rtl/esc_ser_picker.sv
module esc_ser_picker #(
    parameter int           W         = 8,
    parameter logic [W-1:0] SYNC_CODE = W'(esc_ser_pkg::SYNC_DEF),
    parameter logic [W-1:0] IDLE_CODE = W'(esc_ser_pkg::IDLE_DEF),
    parameter logic [W-1:0] ESC_CODE  = W'(esc_ser_pkg::ESC_DEF)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         last_bit,
    input  logic         next_is_sync,
    input  logic         tx_en,
    input  logic         fifo_valid,
    input  logic [W-1:0] fifo_data,
    output logic         fifo_ready,
    output logic [W-1:0] load_byte,
    output logic         holding
);
    typedef struct packed {
        logic         held;
        logic [W-1:0] held_byte;
    } pick_t;

    pick_t p_d, p_q;
    logic  take;
    logic  reserved;

    always_comb begin
        p_d        = p_q;
        fifo_ready = last_bit && !next_is_sync && !p_q.held && tx_en;
        take       = fifo_ready && fifo_valid;
        reserved   = (fifo_data == IDLE_CODE) || (fifo_data == ESC_CODE);
        load_byte  = IDLE_CODE;
        if (next_is_sync) begin
            load_byte = SYNC_CODE;
        end else if (p_q.held) begin
            load_byte = p_q.held_byte;
            if (last_bit) p_d.held = 1'b0;
        end else if (take) begin
            if (reserved) begin
                load_byte     = ESC_CODE;
                p_d.held      = 1'b1;
                p_d.held_byte = fifo_data;
            end else begin
                load_byte     = fifo_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign holding = p_q.held;

    // R10: a held byte is released at the next non-sync slot boundary
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !next_is_sync && p_q.held) |=> !p_q.held);
endmodule

// File: rtl/esc_ser_tx.sv
module esc_ser_tx #(
    parameter int           W           = esc_ser_pkg::CHAR_W,
    parameter int           FRAME_SLOTS = 7,
    parameter logic [W-1:0] SYNC_CODE   = W'(esc_ser_pkg::SYNC_DEF),
    parameter logic [W-1:0] IDLE_CODE   = W'(esc_ser_pkg::IDLE_DEF),
    parameter logic [W-1:0] ESC_CODE    = W'(esc_ser_pkg::ESC_DEF)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         fifo_valid,
    input  logic [W-1:0] fifo_data,
    output logic         fifo_ready,
    output logic         ser_bit,
    output logic         slot_start
);
    localparam int SW = $clog2(FRAME_SLOTS);

    typedef struct packed {
        logic [W-1:0] sh;
    } tx_t;

    tx_t           t_d, t_q;
    logic          first_bit, last_bit, next_is_sync, holding;
    logic [SW-1:0] slot_idx;
    logic [W-1:0]  load_byte;

    esc_ser_timer #(.W(W), .FRAME_SLOTS(FRAME_SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .first_bit(first_bit), .last_bit(last_bit),
        .next_is_sync(next_is_sync), .slot_idx(slot_idx)
    );

    esc_ser_picker #(.W(W), .SYNC_CODE(SYNC_CODE), .IDLE_CODE(IDLE_CODE),
                     .ESC_CODE(ESC_CODE)) u_pick (
        .clk(clk), .rst_n(rst_n), .last_bit(last_bit), .next_is_sync(next_is_sync),
        .tx_en(tx_en), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_ready(fifo_ready), .load_byte(load_byte), .holding(holding)
    );

    always_comb begin
        t_d = t_q;
        if (last_bit) t_d.sh = load_byte;
        else          t_d.sh = {t_q.sh[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.sh <= SYNC_CODE;
        else        t_q    <= t_d;
    end

    assign ser_bit    = t_q.sh[W-1];
    assign slot_start = first_bit;

    // R2: inside a slot the byte moves one place toward the output per clock
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !last_bit |=> t_q.sh[W-1:1] == $past(t_q.sh[W-2:0]));

    // R3: the first bit of slot 0 belongs to the sync code
    p_sync_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (first_bit && slot_idx == '0) |-> t_q.sh == SYNC_CODE);

    // R4: nothing offered and nothing held gives idle
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !next_is_sync && !holding && !fifo_valid) |=> t_q.sh == IDLE_CODE);

    // R6: a reserved byte taken at the boundary opens with the escape code
    p_esc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ready && fifo_valid && (fifo_data == IDLE_CODE || fifo_data == ESC_CODE))
        |=> t_q.sh == ESC_CODE);

    // R9: with intake disabled and nothing held, a non-sync slot is idle
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !next_is_sync && !holding && !tx_en) |=> t_q.sh == IDLE_CODE);
endmodule

// File: tb/sim_esc_ser_tx.sv
module sim_esc_ser_tx;
    localparam int CLK_P = 10;

    // {expected escaped, data byte}
    localparam logic [8:0] VEC [0:11] = '{
        {1'b0, 8'h11}, {1'b1, 8'h81}, {1'b0, 8'hB2}, {1'b1, 8'hE7},
        {1'b0, 8'h22}, {1'b0, 8'h33}, {1'b1, 8'h81}, {1'b0, 8'h44},
        {1'b1, 8'hE7}, {1'b0, 8'hB2}, {1'b0, 8'h55}, {1'b0, 8'h66}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       fifo_valid, fifo_ready, ser_bit, slot_start;
    logic [7:0] fifo_data;

    logic [7:0] q [0:63];
    int         qn = 0;
    int         qh;

    int         checks = 0, errors = 0;
    int         ns, bitn, bad_strobe, bad_ready, dis_pop;
    logic [7:0] cur;
    logic [7:0] slots [0:63];
    logic [7:0] dec [0:63];
    logic       decesc [0:63];
    int         nd, bad_sync;

    always #(CLK_P/2) clk = ~clk;

    assign fifo_valid = (qh < qn);
    assign fifo_data  = q[qh[5:0]];

    esc_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .fifo_ready(fifo_ready), .ser_bit(ser_bit),
        .slot_start(slot_start)
    );

    always @(posedge clk) begin
        if (!rst_n)                        qh <= 0;
        else if (fifo_ready && fifo_valid) qh <= qh + 1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            ns = 0; bitn = 0; bad_strobe = 0; bad_ready = 0; dis_pop = 0; cur = 8'h00;
        end else begin
            if (slot_start !== (bitn == 0)) bad_strobe++;
            if (fifo_ready && bitn != 7)    bad_ready++;
            if (fifo_ready && !tx_en)       dis_pop++;
            cur = {cur[6:0], ser_bit};
            if (bitn == 7) begin
                if (ns < 64) slots[ns] = cur;
                ns++;
                bitn = 0;
            end else begin
                bitn++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        qn = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_slots(input int n);
        while (ns < n) @(negedge clk);
    endtask

    task automatic decode();
        logic pend = 1'b0;
        int   lim = (ns < 64) ? ns : 64;
        nd = 0; bad_sync = 0;
        for (int i = 0; i < lim; i++) begin
            if (i % 7 == 0) begin
                if (slots[i] != 8'hB2) bad_sync++;
            end else if (pend) begin
                dec[nd] = slots[i]; decesc[nd] = 1'b1; nd++; pend = 1'b0;
            end else if (slots[i] == 8'hE7) begin
                pend = 1'b1;
            end else if (slots[i] != 8'h81) begin
                dec[nd] = slots[i]; decesc[nd] = 1'b0; nd++;
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad_idle;
        // ---- table walk: reset state, ordering, escapes, plain 0xB2
        for (int i = 0; i < 12; i++) q[i] = VEC[i][7:0];
        tx_en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        qn = 12;
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(slot_start == 1'b1, "R1 slot_start after reset", int'(slot_start), 1);
        chk(ser_bit == 1'b1, "R1 sync MSB after reset", int'(ser_bit), 1);
        chk(fifo_ready == 1'b0, "R1 no ready after reset", int'(fifo_ready), 0);
        wait_slots(28);
        decode();
        chk(bad_sync == 0, "R3 sync every 7th slot", bad_sync, 0);
        chk(slots[0] == 8'hB2, "R3 first slot is sync", int'(slots[0]), 'hB2);
        chk(bad_strobe == 0, "R2 slot strobe spacing", bad_strobe, 0);
        chk(bad_ready == 0, "R5 ready only in last bit", bad_ready, 0);
        chk(nd == 12, "R5 data count", nd, 12);
        for (int i = 0; i < 12; i++) begin
            chk(dec[i] == VEC[i][7:0], VEC[i][8] ? "R6 escaped byte value" :
                (VEC[i][7:0] == 8'hB2 ? "R7 plain sync-valued byte" : "R5 byte order"),
                int'(dec[i]), int'(VEC[i][7:0]));
            chk(decesc[i] == VEC[i][8], VEC[i][8] ? "R6 escape prefix present" :
                "R7 no escape prefix", int'(decesc[i]), int'(VEC[i][8]));
        end

        // ---- escape split across the sync slot, second byte waiting behind it
        do_reset();
        wait_slots(5);
        @(posedge clk);
        #1 begin q[0] = 8'h81; q[1] = 8'h66; qn = 2; end
        wait_slots(12);
        bad_idle = 0;
        for (int i = 1; i < 5; i++) if (slots[i] != 8'h81) bad_idle++;
        chk(bad_idle == 0, "R4 idle with empty queue", bad_idle, 0);
        chk(slots[6] == 8'hE7, "R8 escape in slot 6", int'(slots[6]), 'hE7);
        chk(slots[7] == 8'hB2, "R8 sync after split escape", int'(slots[7]), 'hB2);
        chk(slots[8] == 8'h81, "R8 escaped byte after sync", int'(slots[8]), 'h81);
        chk(slots[9] == 8'h66, "R10 waiting byte kept and sent", int'(slots[9]), 'h66);
        chk(qh == 2, "R10 pop count", qh, 2);

        // ---- intake disabled, then a held byte across the disable
        tx_en = 1'b0;
        do_reset();
        #1 begin q[0] = 8'hE7; q[1] = 8'h55; q[2] = 8'h66; qn = 3; end
        wait_slots(16);
        bad_idle = 0;
        for (int i = 0; i < 16; i++)
            if (slots[i] != ((i % 7 == 0) ? 8'hB2 : 8'h81)) bad_idle++;
        chk(bad_idle == 0, "R9 only sync and idle while disabled", bad_idle, 0);
        chk(qh == 0, "R9 no pop while disabled", qh, 0);
        @(posedge clk);
        #1 tx_en = 1'b1;
        while (qh < 1) @(negedge clk);
        @(posedge clk);
        #1 tx_en = 1'b0;
        wait_slots(ns + 8);
        decode();
        chk(dis_pop == 0, "R9 ready low while disabled", dis_pop, 0);
        chk(qh == 1, "R9 single pop across enable window", qh, 1);
        chk(nd == 1, "R9 held byte count", nd, 1);
        chk(nd >= 1 && dec[0] == 8'hE7 && decesc[0], "R9 held byte still sent",
            int'(dec[0]), 'hE7);
        chk(bad_sync == 0, "R3 sync kept while disabled", bad_sync, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule